// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block receives configuration writes over a write-only serial link made of a serial clock, a serial data line and an active-low select. Each transfer is a 16-bit word sent most significant bit first. The two top bits carry nothing. The next four bits pick one of nine 10-bit configuration registers, and the low ten bits are the value to store. The received word is handed across into the system clock domain. There it is decoded and written into the register bank, and the bank drives every register value and a handful of decoded control fields to the neighbouring blocks.

Two bits of the control register are actions and are never stored. One of them returns the whole bank to its reset values. The other asks the black-level averager to drop its accumulated result. Each action produces a single-cycle strobe in the system clock domain. The control register also holds a standby request, the power-down bits for two user DACs, and two calibration-mode bits. The block reduces these to a standby output, which also follows an active-low standby pin, and to the auto-mode enables for the coarse and fine offset loops. The serial link and the bank are not stream interfaces. The link has no back-pressure, and the sender must leave enough time between frames.

Top module: `cfg_serial_port`

## Requirements
- R1: After the active-low hardware reset, the target black level register reads 0x040, the averaging configuration reads 0x003, the test register reads 0x280, and every other register reads zero.
- R2: A frame is taken most significant bit first. Frame bits 15:14 are ignored, bits 13:10 form the address and bits 9:0 the data. Address 0 is control, 1 gain, 2 and 3 the user DAC codes, 4 coarse offset, 5 fine offset, 6 target black level, 7 averaging configuration and 8 test. A write changes only the addressed register.
- R3: A frame is committed only if exactly 16 serial clock rising edges occur while select is low. Frames of 15 or 17 edges, and clock edges seen while select is high, change nothing.
- R4: Frames addressed 9 to 15 leave all nine registers unchanged.
- R5: A control write with data bit 0 set returns every register, control included, to its R1 value. It raises `soft_rst_pulse` for exactly one cycle.
- R6: A control write with data bit 1 set raises `avg_clr_pulse` for exactly one cycle. Control bits 1:0 always read back zero, and the other bits of that write are stored.
- R7: `standby` is high when control bit 9 is set or when `stby_n` is low. `dac1_pd` follows control bit 8 and `dac2_pd` follows control bit 7.
- R8: `fine_auto` is high when control bit 5 is clear. `coarse_auto` is high only when control bits 6 and 5 are both clear.
- R9: Writes are accepted while `standby` is high.
- R10: With select rising just after a falling system clock edge, the registers and strobes take the new values at the third rising edge. They keep the old values after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| stby_n | input | 1 | Active-low standby pin |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdata | input | 1 | Serial data |
| sel_n | input | 1 | Active-low frame select |
| ctrl_q | output | 10 | Control register (bits 1:0 read zero) |
| gain_q | output | 10 | Gain register |
| dac1_q | output | 10 | User DAC 1 code |
| dac2_q | output | 10 | User DAC 2 code |
| coarse_q | output | 10 | Coarse offset register |
| fine_q | output | 10 | Fine offset register |
| black_q | output | 10 | Target black level |
| avgcfg_q | output | 10 | Black-averaging configuration |
| test_q | output | 10 | Test register |
| standby | output | 1 | Combined standby request |
| dac1_pd | output | 1 | User DAC 1 power-down |
| dac2_pd | output | 1 | User DAC 2 power-down |
| coarse_auto | output | 1 | Coarse offset loop in auto mode |
| fine_auto | output | 1 | Fine offset loop in auto mode |
| soft_rst_pulse | output | 1 | One-cycle bank reset strobe |
| avg_clr_pulse | output | 1 | One-cycle averager clear strobe |

## Verification
The rising select edge flips a toggle. That toggle needs two system clock edges to cross, and the register write lands on the third edge, together with either action strobe. The latency checks raise select just after a falling clock edge. They sample at the falling edge after the second rising edge, where the old values must still show, and again after the third, where the new value must show. All other frames wait five rising edges and then sample at a falling edge, which is safely past the write. The strobes are counted at every falling edge, so a count that grows by more than one per write reveals a strobe that lasted too long.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_FRAME_W  = 16;
  localparam int CFG_ADDR_W   = 4;
  localparam int CFG_DATA_W   = 10;
  localparam int CFG_NUM_REGS = 9;

  typedef enum logic [CFG_ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_GAIN   = 4'd1,
    A_DAC1   = 4'd2,
    A_DAC2   = 4'd3,
    A_COARSE = 4'd4,
    A_FINE   = 4'd5,
    A_BLACK  = 4'd6,
    A_AVG    = 4'd7,
    A_TEST   = 4'd8
  } cfg_addr_e;

  // control register bit positions
  localparam int CB_SOFTRST  = 0;
  localparam int CB_AVGCLR   = 1;
  localparam int CB_FINE_BYP = 5;
  localparam int CB_CRS_BYP  = 6;
  localparam int CB_PD2      = 7;
  localparam int CB_PD1      = 8;
  localparam int CB_STBY     = 9;

  function automatic logic [CFG_DATA_W-1:0] reg_default(input int idx);
    case (idx)
      int'(A_BLACK): return CFG_DATA_W'(10'h040);
      int'(A_AVG):   return CFG_DATA_W'(10'h003);
      int'(A_TEST):  return CFG_DATA_W'(10'h280);
      default:       return '0;
    endcase
  endfunction

  // bits that are stored on a write; action bits of control are dropped
  function automatic logic [CFG_DATA_W-1:0] reg_keep_mask(input int idx);
    logic [CFG_DATA_W-1:0] m;
    m = '1;
    if (idx == int'(A_CTRL)) begin
      m[CB_SOFTRST] = 1'b0;
      m[CB_AVGCLR]  = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int FRAME_W = cfg_pkg::CFG_FRAME_W
) (
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdata,
  input  logic               sel_n,
  output logic [FRAME_W-1:0] word_hold,
  output logic               word_tog
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               clr;

  assign clr = sel_n | ~rst_n;

  // shift register and edge counter live only while select is low
  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      shreg <= {shreg[FRAME_W-2:0], sdata};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // commit on select release when the frame length was exact
  always_ff @(posedge sel_n or negedge rst_n) begin
    if (!rst_n) begin
      word_hold <= '0;
      word_tog  <= 1'b0;
    end else if (bit_cnt == CNT_FULL) begin
      word_hold <= shreg;
      word_tog  <= ~word_tog;
    end
  end
endmodule

// File: rtl/cfg_toggle_sync.sv
module cfg_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], tog_in};
  end

  assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int ADDR_W   = CFG_ADDR_W,
  parameter int DATA_W   = CFG_DATA_W,
  parameter int NUM_REGS = CFG_NUM_REGS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic                       soft_rst_pulse,
  output logic                       avg_clr_pulse
);
  logic ctrl_hit, soft_hit, avg_hit;

  assign ctrl_hit = wr_stb && (wr_addr == ADDR_W'(A_CTRL));
  assign soft_hit = ctrl_hit && wr_data[CB_SOFTRST];
  assign avg_hit  = ctrl_hit && wr_data[CB_AVGCLR];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF  = DATA_W'(reg_default(i));
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(reg_keep_mask(i));
    logic [DATA_W-1:0] r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= DEF;
      else if (soft_hit)
        r_q <= DEF;
      else if (wr_stb && wr_addr == ADDR_W'(i))
        r_q <= wr_data & KEEP;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_pulse <= 1'b0;
      avg_clr_pulse  <= 1'b0;
    end else begin
      soft_rst_pulse <= soft_hit;
      avg_clr_pulse  <= avg_hit;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_pkg::*;
#(
  parameter int FRAME_W     = CFG_FRAME_W,
  parameter int ADDR_W      = CFG_ADDR_W,
  parameter int DATA_W      = CFG_DATA_W,
  parameter int NUM_REGS    = CFG_NUM_REGS,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sel_n,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] dac1_q,
  output logic [DATA_W-1:0] dac2_q,
  output logic [DATA_W-1:0] coarse_q,
  output logic [DATA_W-1:0] fine_q,
  output logic [DATA_W-1:0] black_q,
  output logic [DATA_W-1:0] avgcfg_q,
  output logic [DATA_W-1:0] test_q,
  output logic              standby,
  output logic              dac1_pd,
  output logic              dac2_pd,
  output logic              coarse_auto,
  output logic              fine_auto,
  output logic              soft_rst_pulse,
  output logic              avg_clr_pulse
);
  localparam int ADDR_LSB = DATA_W;
  localparam int ADDR_MSB = DATA_W + ADDR_W - 1;

  logic [FRAME_W-1:0]         word_hold;
  logic                       word_tog;
  logic                       wr_pulse;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  cfg_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .rst_n     (rst_n),
    .sclk      (sclk),
    .sdata     (sdata),
    .sel_n     (sel_n),
    .word_hold (word_hold),
    .word_tog  (word_tog)
  );

  cfg_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tog_in (word_tog),
    .pulse  (wr_pulse)
  );

  cfg_reg_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_stb         (wr_pulse),
    .wr_addr        (word_hold[ADDR_MSB:ADDR_LSB]),
    .wr_data        (word_hold[DATA_W-1:0]),
    .regs_flat      (regs_flat),
    .soft_rst_pulse (soft_rst_pulse),
    .avg_clr_pulse  (avg_clr_pulse)
  );

  assign ctrl_q   = regs_flat[int'(A_CTRL)*DATA_W   +: DATA_W];
  assign gain_q   = regs_flat[int'(A_GAIN)*DATA_W   +: DATA_W];
  assign dac1_q   = regs_flat[int'(A_DAC1)*DATA_W   +: DATA_W];
  assign dac2_q   = regs_flat[int'(A_DAC2)*DATA_W   +: DATA_W];
  assign coarse_q = regs_flat[int'(A_COARSE)*DATA_W +: DATA_W];
  assign fine_q   = regs_flat[int'(A_FINE)*DATA_W   +: DATA_W];
  assign black_q  = regs_flat[int'(A_BLACK)*DATA_W  +: DATA_W];
  assign avgcfg_q = regs_flat[int'(A_AVG)*DATA_W    +: DATA_W];
  assign test_q   = regs_flat[int'(A_TEST)*DATA_W   +: DATA_W];

  // decoded control fields
  assign standby     = ~stby_n | ctrl_q[CB_STBY];
  assign dac1_pd     = ctrl_q[CB_PD1];
  assign dac2_pd     = ctrl_q[CB_PD2];
  assign fine_auto   = ~ctrl_q[CB_FINE_BYP];
  assign coarse_auto = ~ctrl_q[CB_CRS_BYP] & ~ctrl_q[CB_FINE_BYP];
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int DATA_W = cfg_pkg::CFG_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_pulse,
  input logic              soft_rst_pulse,
  input logic              avg_clr_pulse,
  input logic              coarse_auto,
  input logic              fine_auto,
  input logic [DATA_W-1:0] gain_q,
  input logic [DATA_W-1:0] black_q,
  input logic [DATA_W-1:0] avgcfg_q,
  input logic [DATA_W-1:0] test_q
);
  AST_SOFT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse); // R5
  AST_SOFT_RESTORES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (black_q == DATA_W'(10'h040) && avgcfg_q == DATA_W'(10'h003)
                        && test_q == DATA_W'(10'h280) && gain_q == '0)); // R5
  AST_AVG_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    avg_clr_pulse |=> !avg_clr_pulse); // R6
  AST_COARSE_IMPLIES_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_auto |-> fine_auto); // R8
  AST_GAIN_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> $past(wr_pulse)); // R10
  AST_STROBE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_pulse || avg_clr_pulse) |-> $past(wr_pulse)); // R10
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_pulse       (wr_pulse),
  .soft_rst_pulse (soft_rst_pulse),
  .avg_clr_pulse  (avg_clr_pulse),
  .coarse_auto    (coarse_auto),
  .fine_auto      (fine_auto),
  .gain_q         (gain_q),
  .black_q        (black_q),
  .avgcfg_q       (avgcfg_q),
  .test_q         (test_q)
);

// File: tb/test_cfg_serial_port.sv
`timescale 1ns/1ps
module test_cfg_serial_port;
  logic clk = 1'b0, rst_n = 1'b0, stby_n = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sel_n = 1'b1;
  logic [9:0] ctrl_q, gain_q, dac1_q, dac2_q, coarse_q, fine_q, black_q, avgcfg_q, test_q;
  logic standby, dac1_pd, dac2_pd, coarse_auto, fine_auto, soft_rst_pulse, avg_clr_pulse;

  int checks = 0, errors = 0;
  int n_soft = 0, n_avg = 0;
  logic [9:0] exp_r [9];

  always #10 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sclk(sclk), .sdata(sdata), .sel_n(sel_n),
    .ctrl_q(ctrl_q), .gain_q(gain_q), .dac1_q(dac1_q), .dac2_q(dac2_q),
    .coarse_q(coarse_q), .fine_q(fine_q), .black_q(black_q), .avgcfg_q(avgcfg_q),
    .test_q(test_q), .standby(standby), .dac1_pd(dac1_pd), .dac2_pd(dac2_pd),
    .coarse_auto(coarse_auto), .fine_auto(fine_auto),
    .soft_rst_pulse(soft_rst_pulse), .avg_clr_pulse(avg_clr_pulse)
  );

  always @(negedge clk) begin
    if (soft_rst_pulse) n_soft++;
    if (avg_clr_pulse)  n_avg++;
  end

  task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < 9; i++) exp_r[i] = 10'h000;
    exp_r[6] = 10'h040;
    exp_r[7] = 10'h003;
    exp_r[8] = 10'h280;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [9:0] d);
    if (a == 4'd0) begin
      if (d[0]) model_defaults();
      else      exp_r[0] = d & 10'h3FC;
    end else if (a < 4'd9) begin
      exp_r[a] = d;
    end
  endtask

  task automatic chk_all(input string req);
    chk(ctrl_q,   exp_r[0], req, "ctrl");
    chk(gain_q,   exp_r[1], req, "gain");
    chk(dac1_q,   exp_r[2], req, "dac1");
    chk(dac2_q,   exp_r[3], req, "dac2");
    chk(coarse_q, exp_r[4], req, "coarse");
    chk(fine_q,   exp_r[5], req, "fine");
    chk(black_q,  exp_r[6], req, "black");
    chk(avgcfg_q, exp_r[7], req, "avgcfg");
    chk(test_q,   exp_r[8], req, "test");
  endtask

  task automatic shift_bits(input int n, input logic [31:0] w);
    sel_n = 1'b0;
    #15;
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
    end
    #10;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] lead, input logic [3:0] a, input logic [9:0] d);
    shift_bits(16, {16'h0, lead, a, d});
    sel_n = 1'b1;
    model_write(a, d);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=timeout exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, a0;
    logic [9:0] d;
    model_defaults();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_all("R1");
    chk({9'd0, standby},     10'd0, "R7", "standby");
    chk({9'd0, coarse_auto}, 10'd1, "R8", "coarse_auto");
    chk({9'd0, fine_auto},   10'd1, "R8", "fine_auto");

    // R2 / R4 address sweep with two data patterns
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 16; a++) begin
        d = 10'((a * 83 + p * 401 + 17) % 1024);
        if (a == 0) d = d & 10'h3FC;
        frame(p == 0 ? 2'b00 : 2'b11, 4'(a), d);
        chk_all(a < 9 ? "R2" : "R4");
      end
    end

    // R3 wrong frame lengths and clocks without select
    shift_bits(15, {17'h0, 4'd1, 10'h155} >> 1);
    sel_n = 1'b1; settle(); chk_all("R3");
    shift_bits(17, {15'h0, 2'b00, 4'd1, 10'h155, 1'b1});
    sel_n = 1'b1; settle(); chk_all("R3");
    for (int i = 0; i < 16; i++) begin
      sdata = i[0];
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
    end
    settle(); chk_all("R3");

    // R7 decoded power fields
    frame(2'b00, 4'd0, 10'h380);
    chk({9'd0, standby}, 10'd1, "R7", "standby bit9");
    chk({9'd0, dac1_pd}, 10'd1, "R7", "dac1_pd");
    chk({9'd0, dac2_pd}, 10'd1, "R7", "dac2_pd");
    frame(2'b00, 4'd0, 10'h100);
    chk({9'd0, standby}, 10'd0, "R7", "standby cleared");
    chk({9'd0, dac2_pd}, 10'd0, "R7", "dac2_pd cleared");
    stby_n = 1'b0;
    #1;
    chk({9'd0, standby}, 10'd1, "R7", "standby pin");

    // R9 writes while in standby
    frame(2'b00, 4'd1, 10'h1A7);
    chk_all("R9");
    stby_n = 1'b1;

    // R8 all four bypass combinations
    for (int m = 0; m < 4; m++) begin
      frame(2'b00, 4'd0, 10'(m) << 5);
      chk({9'd0, fine_auto},   {9'd0, ~m[0]},          "R8", "fine_auto");
      chk({9'd0, coarse_auto}, {9'd0, ~m[0] & ~m[1]},  "R8", "coarse_auto");
    end

    // R6 averager clear
    s0 = n_soft; a0 = n_avg;
    frame(2'b00, 4'd0, 10'h202);
    chk_all("R6");
    chk(10'(n_avg - a0),  10'd1, "R6", "avg strobe cycles");
    chk(10'(n_soft - s0), 10'd0, "R6", "no soft strobe");

    // R5 soft reset of the whole bank
    frame(2'b00, 4'd6, 10'h3FF);
    frame(2'b00, 4'd8, 10'h001);
    s0 = n_soft;
    frame(2'b00, 4'd0, 10'h3C1);
    chk_all("R5");
    chk(10'(n_soft - s0), 10'd1, "R5", "soft strobe cycles");

    // R10 latency with select released just after a falling edge
    shift_bits(16, {16'h0, 2'b00, 4'd1, 10'h2C3});
    @(negedge clk); sel_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(gain_q, exp_r[1], "R10", "gain before third edge");
    @(posedge clk); @(negedge clk);
    model_write(4'd1, 10'h2C3);
    chk(gain_q, exp_r[1], "R10", "gain at third edge");
    shift_bits(16, {16'h0, 2'b00, 4'd0, 10'h001});
    @(negedge clk); sel_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({9'd0, soft_rst_pulse}, 10'd0, "R10", "strobe before third edge");
    @(posedge clk); @(negedge clk);
    chk({9'd0, soft_rst_pulse}, 10'd1, "R10", "strobe at third edge");
    @(posedge clk); @(negedge clk);
    chk({9'd0, soft_rst_pulse}, 10'd0, "R10", "strobe after one cycle");
    model_write(4'd0, 10'h001);
    chk_all("R10");

    // R1 hardware reset mid-run
    frame(2'b00, 4'd3, 10'h0F0);
    frame(2'b00, 4'd7, 10'h155);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_defaults();
    @(negedge clk);
    chk_all("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule